// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Decoder

This block listens to a keyboard on the two open-collector PS/2 lines, clock and data, and turns the serial stream into key events. Each 11-bit frame is checked before it is used. A good frame carries one byte. The block follows the two prefix bytes across frames: `E0` marks an extended key and `F0` marks a release. When the final scan code of a sequence arrives, the block emits one key event. The event carries the 8-bit code, a released flag and an extended flag.

A frame whose parity or stop bit is wrong raises a one-cycle error strobe. Its byte is thrown away. A frame that stalls in the middle is dropped after a programmable quiet interval, so the next start bit is taken cleanly. Only the keyboard-to-host direction is handled. Both PS/2 lines are inputs.

Top module: `ps2kb_decoder`

## Requirements
- R1: After reset, `key_vld_o`, `frm_err_o`, `key_code_o`, `key_rel_o` and `key_ext_o` are all zero.
- R2: Frame format:
  - A frame is a 0 start bit, then 8 data bits least significant bit first, then a parity bit that makes the ones count of data plus parity odd, then a 1 stop bit.
  - Each bit is taken on a falling edge of the PS/2 clock.
  - A good frame whose byte is neither `E0` nor `F0`, with no prefix pending, gives exactly one `key_vld_o` pulse with `key_code_o` equal to the byte and both flags 0.
- R3: A good `F0` frame followed by a good code frame gives one event with `key_rel_o`=1 and `key_ext_o`=0.
- R4: A good `E0` frame followed by a good code frame gives one event with `key_ext_o`=1 and `key_rel_o`=0.
- R5: The sequence `E0`, `F0`, code gives one event with both flags 1.
- R6: A prefix byte (`E0` or `F0`) on its own produces no event and no error.
- R7: A frame with wrong parity gives one `frm_err_o` pulse and no event.
- R8: A frame whose stop bit is 0 gives one `frm_err_o` pulse and no event.
- R9: A frame error clears any pending prefix. A code that follows it is reported with both flags 0.
- R10: Both prefix flags are cleared after each emitted event.
- R11: Repeating the same make code produces a new event for every repeat.
- R12: If no PS/2 clock falling edge arrives for `TIMEOUT_CYC` system cycles inside a frame, the partial frame is dropped. The following frame then decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Raw PS/2 clock line, idles high |
| ps2_dat_i | input | 1 | Raw PS/2 data line, idles high |
| key_vld_o | output | 1 | One-cycle strobe: a key event is presented |
| key_code_o | output | 8 | Scan code of the event |
| key_rel_o | output | 1 | Event is a key release |
| key_ext_o | output | 1 | Event is an extended key |
| frm_err_o | output | 1 | One-cycle strobe: bad parity or stop bit |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 40 and two synchroniser stages. It drives the PS/2 clock with a half period of four system cycles. This makes a full frame short enough that every one of the 254 non-prefix codes can be sent as a make. A strided subset of codes then goes through the release, extended and extended-release sequences. The small timeout puts the stalled-frame recovery within a few dozen cycles. The bench also covers:
- error frames placed between a prefix and a code;
- bare prefixes;
- repeated makes.

// File: rtl/ps2kb_pkg.sv
package ps2kb_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned FRAME_BITS = DATA_W + 3;
    localparam int unsigned BCNT_W     = $clog2(FRAME_BITS + 1);

    localparam logic [DATA_W-1:0] PFX_EXT = 8'hE0;
    localparam logic [DATA_W-1:0] PFX_REL = 8'hF0;

    typedef struct packed {
        logic [DATA_W-1:0] code;
        logic              rel;
        logic              ext;
    } key_evt_t;

    // odd parity over data+parity and a high stop bit
    function automatic logic frame_good(input logic [DATA_W-1:0] d,
                                        input logic par,
                                        input logic stop);
        return (^{d, par}) & stop;
    endfunction

    function automatic logic is_prefix(input logic [DATA_W-1:0] d);
        return (d == PFX_EXT) || (d == PFX_REL);
    endfunction

endpackage

// File: rtl/ps2kb_sync.sv
module ps2kb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ps2_clk,
    input  logic ps2_dat,
    output logic dat_s,
    output logic fall
);
    logic [STAGES-1:0] clk_sh;
    logic [STAGES-1:0] dat_sh;
    logic              clk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sh <= '1;
            dat_sh <= '1;
            clk_d  <= 1'b1;
        end else begin
            clk_sh <= {clk_sh[STAGES-2:0], ps2_clk};
            dat_sh <= {dat_sh[STAGES-2:0], ps2_dat};
            clk_d  <= clk_sh[STAGES-1];
        end
    end

    assign dat_s = dat_sh[STAGES-1];
    assign fall  = clk_d & ~clk_sh[STAGES-1];

    a_r2_fall_is_edge: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
endmodule

// File: rtl/ps2kb_frame.sv
module ps2kb_frame
    import ps2kb_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 25000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              dat,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_o,
    output logic              frm_err
);
    localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [BCNT_W-1:0] LAST_DATA = BCNT_W'(DATA_W);
    localparam logic [BCNT_W-1:0] PAR_POS   = BCNT_W'(DATA_W + 1);

    logic [BCNT_W-1:0] bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic [TMO_W-1:0]  tmo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            par_q    <= 1'b0;
            tmo_cnt  <= '0;
            byte_vld <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            frm_err  <= 1'b0;
            if (fall) begin
                tmo_cnt <= '0;
                if (bit_cnt == '0) begin
                    if (!dat) bit_cnt <= BCNT_W'(1);
                end else if (bit_cnt <= LAST_DATA) begin
                    shreg   <= {dat, shreg[DATA_W-1:1]};
                    bit_cnt <= bit_cnt + BCNT_W'(1);
                end else if (bit_cnt == PAR_POS) begin
                    par_q   <= dat;
                    bit_cnt <= bit_cnt + BCNT_W'(1);
                end else begin
                    bit_cnt <= '0;
                    if (frame_good(shreg, par_q, dat)) byte_vld <= 1'b1;
                    else                               frm_err  <= 1'b1;
                end
            end else if (bit_cnt != '0) begin
                if (tmo_cnt == TMO_W'(TIMEOUT_CYC - 1)) begin
                    bit_cnt <= '0;
                    tmo_cnt <= '0;
                end else begin
                    tmo_cnt <= tmo_cnt + TMO_W'(1);
                end
            end
        end
    end

    assign byte_o = shreg;

    a_r7_vld_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(byte_vld && frm_err));
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= BCNT_W'(FRAME_BITS - 1));
    a_r12_stall_drop: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt != '0 && !fall && tmo_cnt == TMO_W'(TIMEOUT_CYC - 1)) |=> (bit_cnt == '0));
endmodule

// File: rtl/ps2kb_seq.sv
module ps2kb_seq
    import ps2kb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              frm_err_i,
    output key_evt_t          evt,
    output logic              evt_vld,
    output logic              err_o
);
    logic ext_q;
    logic rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q   <= 1'b0;
            rel_q   <= 1'b0;
            evt     <= '0;
            evt_vld <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            evt_vld <= 1'b0;
            err_o   <= frm_err_i;
            if (frm_err_i) begin
                ext_q <= 1'b0;
                rel_q <= 1'b0;
            end else if (byte_vld) begin
                if (byte_i == PFX_EXT) begin
                    ext_q <= 1'b1;
                end else if (byte_i == PFX_REL) begin
                    rel_q <= 1'b1;
                end else begin
                    evt_vld <= 1'b1;
                    evt     <= '{code: byte_i, rel: rel_q, ext: ext_q};
                    ext_q   <= 1'b0;
                    rel_q   <= 1'b0;
                end
            end
        end
    end

    a_r6_prefix_silent: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && is_prefix(byte_i)) |=> !evt_vld);
    a_r10_flags_cleared: assert property (@(posedge clk) disable iff (rst)
        evt_vld |-> (!ext_q && !rel_q));
    a_r9_err_clears: assert property (@(posedge clk) disable iff (rst)
        frm_err_i |=> (!ext_q && !rel_q && !evt_vld));
endmodule

// File: rtl/ps2kb_decoder.sv
module ps2kb_decoder
    import ps2kb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TIMEOUT_CYC = 25000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       key_vld_o,
    output logic [7:0] key_code_o,
    output logic       key_rel_o,
    output logic       key_ext_o,
    output logic       frm_err_o
);
    logic              dat_s;
    logic              fall;
    logic              byte_vld;
    logic [DATA_W-1:0] byte_w;
    logic              ferr;
    key_evt_t          evt;

    ps2kb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ps2_clk(ps2_clk_i), .ps2_dat(ps2_dat_i),
        .dat_s(dat_s), .fall(fall));

    ps2kb_frame #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
        .clk(clk), .rst(rst), .fall(fall), .dat(dat_s),
        .byte_vld(byte_vld), .byte_o(byte_w), .frm_err(ferr));

    ps2kb_seq u_seq (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_i(byte_w),
        .frm_err_i(ferr), .evt(evt), .evt_vld(key_vld_o), .err_o(frm_err_o));

    assign key_code_o = evt.code;
    assign key_rel_o  = evt.rel;
    assign key_ext_o  = evt.ext;

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        key_vld_o |=> !key_vld_o);
    a_r7_event_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(key_vld_o && frm_err_o));
    a_r2_no_prefix_code: assert property (@(posedge clk) disable iff (rst)
        key_vld_o |-> !is_prefix(key_code_o));
endmodule

// File: tb/ps2kb_decoder_bench.sv
module ps2kb_decoder_bench;
    localparam int HP   = 4;
    localparam int GAP  = 30;
    localparam int TMO  = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ps2_clk = 1'b1;
    logic       ps2_dat = 1'b1;
    logic       key_vld_o;
    logic [7:0] key_code_o;
    logic       key_rel_o;
    logic       key_ext_o;
    logic       frm_err_o;

    int n_chk = 0;
    int n_fail = 0;
    int ev_cnt = 0;
    int er_cnt = 0;
    logic [7:0] last_code = '0;
    logic       last_rel = 1'b0;
    logic       last_ext = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ps2kb_decoder #(.SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) u_ps2kb_decoder (
        .clk(clk), .rst(rst), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
        .key_vld_o(key_vld_o), .key_code_o(key_code_o), .key_rel_o(key_rel_o),
        .key_ext_o(key_ext_o), .frm_err_o(frm_err_o));

    always @(negedge clk) begin
        if (!rst && key_vld_o) begin
            ev_cnt++;
            last_code = key_code_o;
            last_rel  = key_rel_o;
            last_ext  = key_ext_o;
        end
        if (!rst && frm_err_o) er_cnt++;
    end

    task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop, input int nbits);
        logic [10:0] f;
        f = {~bad_stop, (~^d) ^ bad_par, d, 1'b0};
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk) ps2_dat = f[i];
            repeat (HP) @(negedge clk);
            ps2_clk = 1'b0;
            repeat (HP) @(negedge clk);
            ps2_clk = 1'b1;
        end
        ps2_dat = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic good(input logic [7:0] d);
        send_frame(d, 1'b0, 1'b0, 11);
    endtask

    task automatic expect_evt(input string req, input int ev0, input int er0,
                              input logic [7:0] code, input bit rel, input bit ext);
        logic [31:0] act, exp;
        act = {8'(ev_cnt - ev0), 4'(er_cnt - er0), last_code, 2'b0, last_rel, last_ext};
        exp = {8'd1, 4'd0, code, 2'b0, rel, ext};
        chk(req, act == exp, act, exp);
    endtask

    task automatic expect_quiet(input string req, input int ev0, input int er0, input int n_err);
        logic [31:0] act, exp;
        act = {16'(ev_cnt - ev0), 16'(er_cnt - er0)};
        exp = {16'd0, 16'(n_err)};
        chk(req, act == exp, act, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int e0, r0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1", {key_vld_o, frm_err_o, key_code_o, key_rel_o, key_ext_o} == '0,
            {key_vld_o, frm_err_o, key_code_o, key_rel_o, key_ext_o}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R2: every non-prefix code as a plain make
        for (int c = 0; c < 256; c++) begin
            if (c == 8'hE0 || c == 8'hF0) continue;
            e0 = ev_cnt; r0 = er_cnt;
            good(8'(c));
            expect_evt("R2", e0, r0, 8'(c), 1'b0, 1'b0);
        end

        // R3, R4, R5 over a strided subset
        for (int c = 1; c < 256; c += 17) begin
            if (c == 8'hE0 || c == 8'hF0) continue;
            e0 = ev_cnt; r0 = er_cnt;
            good(8'hF0); good(8'(c));
            expect_evt("R3", e0, r0, 8'(c), 1'b1, 1'b0);
            e0 = ev_cnt; r0 = er_cnt;
            good(8'hE0); good(8'(c));
            expect_evt("R4", e0, r0, 8'(c), 1'b0, 1'b1);
            e0 = ev_cnt; r0 = er_cnt;
            good(8'hE0); good(8'hF0); good(8'(c));
            expect_evt("R5", e0, r0, 8'(c), 1'b1, 1'b1);
        end

        // R6: bare prefixes are silent
        e0 = ev_cnt; r0 = er_cnt;
        good(8'hE0);
        expect_quiet("R6", e0, r0, 0);
        good(8'hF0);
        expect_quiet("R6", e0, r0, 0);
        good(8'h6B);
        expect_evt("R6", e0, r0, 8'h6B, 1'b1, 1'b1);

        // R7: bad parity
        e0 = ev_cnt; r0 = er_cnt;
        send_frame(8'h1C, 1'b1, 1'b0, 11);
        expect_quiet("R7", e0, r0, 1);

        // R8: bad stop bit
        e0 = ev_cnt; r0 = er_cnt;
        send_frame(8'h32, 1'b0, 1'b1, 11);
        expect_quiet("R8", e0, r0, 1);

        // R9: error wipes pending prefixes
        good(8'hE0); good(8'hF0);
        send_frame(8'h21, 1'b1, 1'b0, 11);
        e0 = ev_cnt; r0 = er_cnt;
        good(8'h1C);
        expect_evt("R9", e0, r0, 8'h1C, 1'b0, 1'b0);

        // R10: flags do not leak into the next event
        good(8'hE0); good(8'hF0); good(8'h74);
        e0 = ev_cnt; r0 = er_cnt;
        good(8'h74);
        expect_evt("R10", e0, r0, 8'h74, 1'b0, 1'b0);

        // R11: repeated make codes
        e0 = ev_cnt; r0 = er_cnt;
        for (int k = 0; k < 3; k++) good(8'h29);
        chk("R11", (ev_cnt - e0) == 3 && last_code == 8'h29 && er_cnt == r0,
            32'(ev_cnt - e0), 32'd3);

        // R12: stalled partial frame is dropped
        e0 = ev_cnt; r0 = er_cnt;
        send_frame(8'hFF, 1'b0, 1'b0, 5);
        repeat (TMO + 20) @(negedge clk);
        good(8'h5A);
        expect_evt("R12", e0, r0, 8'h5A, 1'b0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule